// File: doc/BRIEF.md
# Hypercube All-Gather Step Controller

This block runs on every node of a binary hypercube of 2^DIMS nodes. It collects every node's data block into a local buffer. Before a run, the host writes the node's own block of BLK words into the buffer through a simple memory port, at word offset node_id·BLK. A start pulse then launches a fixed sequence of steps, one per dimension, from dimension 0 upward. In step i, only the lane for dimension i is active. On that lane the node streams out every block it holds so far, which is its own block plus all blocks received in earlier steps. At the same time it stores the equally long stream coming back from its neighbour across that dimension.

The amount of data doubles from step to step. The regions are aligned so that the outgoing region of one node is exactly the incoming region of its neighbour. After the last step, the buffer holds every node's block in node-index order. A completion pulse then marks that the host may read the result back through the same memory port. Send and receive use independent valid/ready lanes, one pair per dimension, so the link fabric can stall either direction at any time.

Top module: `agather_ctrl`

## Requirements
- R1: While reset is high and after it is released, busy, done, every tx_valid bit and every rx_ready bit read 0 until a start is accepted.
- R2: A start seen while idle begins a run at step 0. Steps follow dimensions 0, 1, …, DIMS-1 in ascending order, and port_sel equals the step number. Only tx_valid and rx_ready bit port_sel may be high while busy. Lane d of tx_data/rx_data is bits d·W upward.
- R3: In step i the node sends exactly BLK·2^i words on lane i. These are the buffer words starting at (node_id with bits below i cleared)·BLK, in ascending address order.
- R4: In step i the node accepts exactly BLK·2^i words on lane i. It writes them at ascending addresses starting at ((node_id XOR 2^i) with bits below i cleared)·BLK.
- R5: Sending and receiving on the active lane proceed in the same cycles. The next lane opens only after both directions of the current step have completed.
- R6: After a run, buffer word b·BLK+k holds word k of the block that node b held at its own offset when its run started, for every node b.
- R7: done is a one-cycle pulse in the cycle after the last word of the final step is accepted, whether that word was sent or received. busy is low in that cycle.
- R8: start is ignored while busy: it restarts no step, and each run produces exactly one done pulse.
- R9: While a tx_valid bit is high and its tx_ready is low, that tx_valid bit and tx_data hold their values into the next cycle.
- R10: While idle, host_we writes host_wdata at host_addr, and host_rdata returns the word at host_addr one cycle after the address is presented. Host writes while busy are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | DIMS | Index of this node in the hypercube |
| start | input | 1 | Launches a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| port_sel | output | SELW | Active dimension (step number) |
| tx_valid | output | DIMS | Per-lane send valid |
| tx_ready | input | DIMS | Per-lane send ready |
| tx_data | output | DIMS·W | Per-lane send data |
| rx_valid | input | DIMS | Per-lane receive valid |
| rx_ready | output | DIMS | Per-lane receive ready |
| rx_data | input | DIMS·W | Per-lane receive data |
| host_we | input | 1 | Host buffer write enable (idle only) |
| host_addr | input | AW | Host buffer address |
| host_wdata | input | W | Host buffer write data |
| host_rdata | output | W | Host buffer read data, one cycle latency |

## Verification
The bench builds eight instances with DIMS=3, BLK=4 and W=16 and wires them as a full 3-cube. Each node therefore goes through steps of 4, 8 and 16 words, with both the low and the high alignment of every group base. Each link is gated by a per-run throttle pattern offset by node and lane. This drives the design through full-speed streaming, send-side stalls with held data, receive-side gaps, and a final word that arrives on either the send or the receive side. Separate runs place a host write and repeated start pulses in the middle of a run.

// File: rtl/agather_pkg.sv
package agather_pkg;

  typedef enum logic {
    AG_IDLE = 1'b0,
    AG_RUN  = 1'b1
  } ag_state_e;

endpackage

// File: rtl/agather_plan.sv
// Step geometry: base addresses of the outgoing and incoming regions and the
// step length, all derived from the node index and the current step.
module agather_plan #(
  parameter int DIMS = 3,
  parameter int BLK  = 4,
  parameter int AW   = 5,
  parameter int CW   = 5,
  parameter int SELW = 2
) (
  input  logic [DIMS-1:0] node_id,
  input  logic [SELW-1:0] step,
  output logic [AW-1:0]   tx_base,
  output logic [AW-1:0]   rx_base,
  output logic [CW-1:0]   step_len
);

  logic [DIMS-1:0] low_mask;
  logic [DIMS-1:0] flip;
  logic [DIMS-1:0] own_grp;
  logic [DIMS-1:0] nbr_grp;

  always_comb begin
    low_mask = '0;
    flip     = '0;
    for (int d = 0; d < DIMS; d++) begin
      if (d < int'(step))  low_mask[d] = 1'b1;
      if (d == int'(step)) flip[d]     = 1'b1;
    end
    own_grp  = node_id & ~low_mask;
    nbr_grp  = (node_id ^ flip) & ~low_mask;
    tx_base  = AW'(own_grp) * AW'(BLK);
    rx_base  = AW'(nbr_grp) * AW'(BLK);
    step_len = CW'(BLK) << step;
  end

endmodule

// File: rtl/agather_txpath.sv
// Send side: issues buffer reads one ahead of the output so that the
// registered RAM output serves directly as the lane data register.
module agather_txpath #(
  parameter int AW = 5,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          active,
  input  logic          out_ready,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic          finished
);

  logic [CW-1:0] issued_q;
  logic [CW-1:0] sent_q;
  logic          tv_q;
  logic          fire;

  assign fire      = tv_q & out_ready;
  assign rd_en     = active & (issued_q != len) & (~tv_q | fire);
  assign rd_addr   = base + AW'(issued_q);
  assign out_valid = tv_q;
  assign finished  = (sent_q + CW'(fire)) == len;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      issued_q <= '0;
      sent_q   <= '0;
      tv_q     <= 1'b0;
    end else begin
      if (rd_en) issued_q <= issued_q + 1'b1;
      if (fire)  sent_q   <= sent_q + 1'b1;
      if (rd_en)     tv_q <= 1'b1;
      else if (fire) tv_q <= 1'b0;
    end
  end

endmodule

// File: rtl/agather_rxpath.sv
// Receive side: accepts the neighbour's stream and places it sequentially.
module agather_rxpath #(
  parameter int AW = 5,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          active,
  input  logic          in_valid,
  input  logic [AW-1:0] base,
  input  logic [CW-1:0] len,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          finished
);

  logic [CW-1:0] cnt_q;

  assign in_ready = active & (cnt_q != len);
  assign wr_en    = in_valid & in_ready;
  assign wr_addr  = base + AW'(cnt_q);
  assign finished = (cnt_q + CW'(wr_en)) == len;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (wr_en)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/agather_buf.sv
// Simple dual-port buffer: one write port, one registered read port.
module agather_buf #(
  parameter int W     = 16,
  parameter int AW    = 5,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/agather_ctrl.sv
module agather_ctrl
  import agather_pkg::*;
#(
  parameter int DIMS = 3,
  parameter int BLK  = 4,
  parameter int W    = 16,
  localparam int NODES = 1 << DIMS,
  localparam int DEPTH = NODES * BLK,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH / 2 + 1),
  localparam int SELW  = (DIMS > 1) ? $clog2(DIMS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIMS-1:0]   node_id,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [SELW-1:0]   port_sel,
  output logic [DIMS-1:0]   tx_valid,
  input  logic [DIMS-1:0]   tx_ready,
  output logic [DIMS*W-1:0] tx_data,
  input  logic [DIMS-1:0]   rx_valid,
  output logic [DIMS-1:0]   rx_ready,
  input  logic [DIMS*W-1:0] rx_data,
  input  logic              host_we,
  input  logic [AW-1:0]     host_addr,
  input  logic [W-1:0]      host_wdata,
  output logic [W-1:0]      host_rdata
);

  ag_state_e       state_q;
  logic [SELW-1:0] step_q;
  logic            done_q;
  logic            active;
  logic            last_step;
  logic            step_end;
  logic            clear;

  logic [AW-1:0]   tx_base;
  logic [AW-1:0]   rx_base;
  logic [CW-1:0]   step_len;

  logic            sel_tx_ready;
  logic            sel_rx_valid;
  logic [W-1:0]    sel_rx_data;

  logic            tx_rd_en;
  logic [AW-1:0]   tx_rd_addr;
  logic            tx_tv;
  logic            tx_fin;
  logic            rx_rdy;
  logic            rx_wr_en;
  logic [AW-1:0]   rx_wr_addr;
  logic            rx_fin;

  logic            buf_we;
  logic [AW-1:0]   buf_waddr;
  logic [W-1:0]    buf_wdata;
  logic            buf_re;
  logic [AW-1:0]   buf_raddr;
  logic [W-1:0]    buf_q;

  assign active    = (state_q == AG_RUN);
  assign last_step = (step_q == SELW'(DIMS - 1));
  assign step_end  = active & tx_fin & rx_fin;
  assign clear     = ~active | step_end;

  assign sel_tx_ready = tx_ready[step_q];
  assign sel_rx_valid = rx_valid[step_q];
  assign sel_rx_data  = rx_data[step_q*W +: W];

  agather_plan #(
    .DIMS(DIMS), .BLK(BLK), .AW(AW), .CW(CW), .SELW(SELW)
  ) u_plan (
    .node_id  (node_id),
    .step     (step_q),
    .tx_base  (tx_base),
    .rx_base  (rx_base),
    .step_len (step_len)
  );

  agather_txpath #(.AW(AW), .CW(CW)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .active    (active),
    .out_ready (sel_tx_ready),
    .base      (tx_base),
    .len       (step_len),
    .rd_en     (tx_rd_en),
    .rd_addr   (tx_rd_addr),
    .out_valid (tx_tv),
    .finished  (tx_fin)
  );

  agather_rxpath #(.AW(AW), .CW(CW)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clear    (clear),
    .active   (active),
    .in_valid (sel_rx_valid),
    .base     (rx_base),
    .len      (step_len),
    .in_ready (rx_rdy),
    .wr_en    (rx_wr_en),
    .wr_addr  (rx_wr_addr),
    .finished (rx_fin)
  );

  // Host owns both buffer ports while idle; the schedule owns them while busy.
  assign buf_we    = active ? rx_wr_en   : host_we;
  assign buf_waddr = active ? rx_wr_addr : host_addr;
  assign buf_wdata = active ? sel_rx_data : host_wdata;
  assign buf_re    = active ? tx_rd_en   : 1'b1;
  assign buf_raddr = active ? tx_rd_addr : host_addr;

  agather_buf #(.W(W), .AW(AW), .DEPTH(DEPTH)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_waddr),
    .wdata (buf_wdata),
    .re    (buf_re),
    .raddr (buf_raddr),
    .rdata (buf_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= AG_IDLE;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        AG_IDLE: begin
          if (start) begin
            state_q <= AG_RUN;
            step_q  <= '0;
          end
        end
        AG_RUN: begin
          if (step_end) begin
            if (last_step) begin
              state_q <= AG_IDLE;
              done_q  <= 1'b1;
            end else begin
              step_q <= step_q + 1'b1;
            end
          end
        end
        default: state_q <= AG_IDLE;
      endcase
    end
  end

  for (genvar d = 0; d < DIMS; d++) begin : g_lane
    assign tx_valid[d]       = tx_tv  & (step_q == SELW'(d));
    assign rx_ready[d]       = rx_rdy & (step_q == SELW'(d));
    assign tx_data[d*W +: W] = buf_q;
  end

  assign busy       = active;
  assign done       = done_q;
  assign port_sel   = step_q;
  assign host_rdata = buf_q;

endmodule

// File: rtl/agather_ctrl_chk.sv
module agather_ctrl_chk #(
  parameter int DIMS = 3,
  parameter int W    = 16,
  parameter int SELW = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              done,
  input logic [SELW-1:0]   port_sel,
  input logic [DIMS-1:0]   tx_valid,
  input logic [DIMS-1:0]   tx_ready,
  input logic [DIMS*W-1:0] tx_data,
  input logic [DIMS-1:0]   rx_ready
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (tx_valid == '0) && (rx_ready == '0));

  // R2
  tx_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid != '0) |-> tx_valid == (DIMS'(1) << port_sel));

  // R2
  rx_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_ready != '0) |-> rx_ready == (DIMS'(1) << port_sel));

  // R2
  first_step_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> port_sel == '0);

  // R2
  step_order_chk: assert property (@(posedge clk) disable iff (rst)
    busy && $past(busy) |->
      (port_sel == $past(port_sel)) || (port_sel == $past(port_sel) + 1'b1));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_valid & ~tx_ready) != '0) |=>
      $stable(tx_data) && (tx_valid == $past(tx_valid)));

endmodule

bind agather_ctrl agather_ctrl_chk #(.DIMS(DIMS), .W(W), .SELW(SELW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .port_sel (port_sel),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .rx_ready (rx_ready)
);

// File: tb/agather_ctrl_test.sv
`timescale 1ns/1ps
module agather_ctrl_test;

  localparam int DIMS  = 3;
  localparam int BLK   = 4;
  localparam int W     = 16;
  localparam int NODES = 1 << DIMS;
  localparam int WORDS = NODES * BLK;
  localparam int AW    = $clog2(WORDS);
  localparam int SELW  = 2;
  localparam int NRUNS = 4;

  // Row: [9:2] link throttle pattern, [1] host write while busy, [0] start pulses while busy
  localparam logic [9:0] RUNS [NRUNS] = '{
    {8'hFF, 1'b0, 1'b0},
    {8'hB6, 1'b1, 1'b0},
    {8'h5A, 1'b0, 1'b1},
    {8'h11, 1'b0, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [7:0] pat = 8'hFF;
  int cur_run = 0;

  logic              busy [NODES];
  logic              done [NODES];
  logic [SELW-1:0]   sel  [NODES];
  logic [DIMS-1:0]   txv  [NODES];
  logic [DIMS-1:0]   txr  [NODES];
  logic [DIMS*W-1:0] txd  [NODES];
  logic [DIMS-1:0]   rxv  [NODES];
  logic [DIMS-1:0]   rxr  [NODES];
  logic [DIMS*W-1:0] rxd  [NODES];
  logic              hwe  [NODES];
  logic [AW-1:0]     hadr [NODES];
  logic [W-1:0]      hwd  [NODES];
  logic [W-1:0]      hrd  [NODES];

  for (genvar n = 0; n < NODES; n++) begin : g_node
    agather_ctrl #(.DIMS(DIMS), .BLK(BLK), .W(W)) uut (
      .clk        (clk),
      .rst        (rst),
      .node_id    (DIMS'(n)),
      .start      (start),
      .busy       (busy[n]),
      .done       (done[n]),
      .port_sel   (sel[n]),
      .tx_valid   (txv[n]),
      .tx_ready   (txr[n]),
      .tx_data    (txd[n]),
      .rx_valid   (rxv[n]),
      .rx_ready   (rxr[n]),
      .rx_data    (rxd[n]),
      .host_we    (hwe[n]),
      .host_addr  (hadr[n]),
      .host_wdata (hwd[n]),
      .host_rdata (hrd[n])
    );
  end

  // Link fabric: lane i of node a meets lane i of node a^(1<<i), each directed link throttled.
  always_comb begin
    for (int a = 0; a < NODES; a++) begin
      for (int i = 0; i < DIMS; i++) begin
        int b;
        logic g;
        b = a ^ (1 << i);
        g = pat[(cyc + a * 3 + i) % 8];
        rxv[b][i] = txv[a][i] & g;
        txr[a][i] = rxr[b][i] & g;
        rxd[b][i*W +: W] = txd[a][i*W +: W];
      end
    end
  end

  function automatic logic [W-1:0] wexp(int run, int addr);
    return {4'(run), 4'(addr / BLK), 8'(addr % BLK)};
  endfunction

  // ---------------- monitor ----------------
  int mon_checks = 0;
  int mon_fails  = 0;
  int txcnt [NRUNS][NODES][DIMS];
  int rxcnt [NRUNS][NODES][DIMS];
  int donecnt [NRUNS][NODES];
  int both_cnt [NRUNS][NODES];
  int last_acc [NODES];
  logic [DIMS-1:0]   prev_stall [NODES];
  logic [DIMS*W-1:0] prev_txd   [NODES];

  initial begin
    for (int r = 0; r < NRUNS; r++)
      for (int n = 0; n < NODES; n++) begin
        donecnt[r][n] = 0;
        both_cnt[r][n] = 0;
        for (int d = 0; d < DIMS; d++) begin
          txcnt[r][n][d] = 0;
          rxcnt[r][n][d] = 0;
        end
      end
    for (int n = 0; n < NODES; n++) begin
      last_acc[n] = 0;
      prev_stall[n] = '0;
      prev_txd[n] = '0;
    end
  end

  task automatic mchk(bit ok, string req, int act, int exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h) at cycle %0d", req, act, act, exp, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      for (int n = 0; n < NODES; n++) begin
        bit any_tx;
        bit any_rx;
        any_tx = 1'b0;
        any_rx = 1'b0;
        if (done[n]) begin
          donecnt[cur_run][n]++;
          mchk(cyc == last_acc[n] + 1, "R7 done one cycle after last word", cyc, last_acc[n] + 1);
          mchk(!busy[n], "R7 busy low with done", int'(busy[n]), 0);
        end
        if (busy[n])
          mchk(((txv[n] | rxr[n]) & ~(DIMS'(1) << sel[n])) == '0, "R2 only selected lane active",
               int'(txv[n] | rxr[n]), int'(DIMS'(1) << sel[n]));
        for (int d = 0; d < DIMS; d++) begin
          if (prev_stall[n][d]) begin
            mchk(txv[n][d] && txd[n][d*W +: W] == prev_txd[n][d*W +: W], "R9 held tx word",
                 int'(txd[n][d*W +: W]), int'(prev_txd[n][d*W +: W]));
          end
          if (txv[n][d] && txr[n][d]) begin
            int addr;
            addr = ((n >> d) << d) * BLK + txcnt[cur_run][n][d];
            mchk(txd[n][d*W +: W] == wexp(cur_run, addr), "R3 sent word content",
                 int'(txd[n][d*W +: W]), int'(wexp(cur_run, addr)));
            for (int e = 0; e < d; e++)
              mchk(txcnt[cur_run][n][e] == (BLK << e) && rxcnt[cur_run][n][e] == (BLK << e),
                   "R5 earlier step complete before send", txcnt[cur_run][n][e] + rxcnt[cur_run][n][e], 2 * (BLK << e));
            txcnt[cur_run][n][d]++;
            any_tx = 1'b1;
            if (d == DIMS - 1) last_acc[n] = cyc;
          end
          if (rxv[n][d] && rxr[n][d]) begin
            for (int e = 0; e < d; e++)
              mchk(txcnt[cur_run][n][e] == (BLK << e) && rxcnt[cur_run][n][e] == (BLK << e),
                   "R5 earlier step complete before receive", txcnt[cur_run][n][e] + rxcnt[cur_run][n][e], 2 * (BLK << e));
            rxcnt[cur_run][n][d]++;
            any_rx = 1'b1;
            if (d == DIMS - 1) last_acc[n] = cyc;
          end
        end
        if (any_tx && any_rx) both_cnt[cur_run][n]++;
        prev_stall[n] = txv[n] & ~txr[n];
        prev_txd[n]   = txd[n];
      end
    end
  end

  // ---------------- directed sequence ----------------
  int t_checks = 0;
  int t_fails  = 0;

  task automatic tchk(bit ok, string req, int act, int exp);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic host_idle();
    for (int n = 0; n < NODES; n++) begin
      hwe[n] = 1'b0;
      hadr[n] = '0;
      hwd[n] = '0;
    end
  endtask

  task automatic check_quiet(string req);
    for (int n = 0; n < NODES; n++) begin
      tchk(!busy[n] && !done[n], req, int'({busy[n], done[n]}), 0);
      tchk(txv[n] == '0 && rxr[n] == '0, req, int'({txv[n], rxr[n]}), 0);
    end
  endtask

  initial begin
    host_idle();
    repeat (4) @(negedge clk);
    check_quiet("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check_quiet("R1 after reset");

    // R10: idle host write then read back with one cycle latency
    hwe[3] = 1'b1; hadr[3] = AW'(5); hwd[3] = 16'h1234;
    @(negedge clk);
    hwe[3] = 1'b0;
    @(negedge clk);
    tchk(hrd[3] == 16'h1234, "R10 host write/read", int'(hrd[3]), 16'h1234);

    for (int r = 0; r < NRUNS; r++) begin
      bit fin;
      int wait_cyc;
      cur_run = r;
      pat = RUNS[r][9:2];

      // load each node's own block
      for (int k = 0; k < BLK; k++) begin
        for (int n = 0; n < NODES; n++) begin
          hwe[n]  = 1'b1;
          hadr[n] = AW'(n * BLK + k);
          hwd[n]  = wexp(r, n * BLK + k);
        end
        @(negedge clk);
      end
      host_idle();

      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (RUNS[r][1]) begin
        hwe[0] = 1'b1; hadr[0] = '0; hwd[0] = 16'hDEAD;   // R10: must be dropped
        @(negedge clk);
        host_idle();
      end
      if (RUNS[r][0]) begin
        repeat (12) @(negedge clk);
        start = 1'b1;                                      // R8: must be ignored
        repeat (3) @(negedge clk);
        start = 1'b0;
      end

      fin = 1'b0;
      wait_cyc = 0;
      while (!fin && wait_cyc < 6000) begin
        @(negedge clk);
        wait_cyc++;
        fin = 1'b1;
        for (int n = 0; n < NODES; n++)
          if (donecnt[r][n] == 0 || busy[n]) fin = 1'b0;
      end
      tchk(fin, "R7 run completes (watchdog)", int'(fin), 1);
      repeat (3) @(negedge clk);

      for (int n = 0; n < NODES; n++) begin
        tchk(donecnt[r][n] == 1, "R8 exactly one done per run", donecnt[r][n], 1);
        for (int d = 0; d < DIMS; d++) begin
          tchk(txcnt[r][n][d] == (BLK << d), "R3 words sent in step", txcnt[r][n][d], BLK << d);
          tchk(rxcnt[r][n][d] == (BLK << d), "R4 words received in step", rxcnt[r][n][d], BLK << d);
        end
      end
      if (r == 0)
        for (int n = 0; n < NODES; n++)
          tchk(both_cnt[r][n] > 0, "R5 concurrent send and receive", both_cnt[r][n], 1);

      // read back every buffer (R6, R4 placement)
      for (int a = 0; a < WORDS; a++) begin
        for (int n = 0; n < NODES; n++) hadr[n] = AW'(a);
        @(negedge clk);
        for (int n = 0; n < NODES; n++)
          tchk(hrd[n] == wexp(r, a), "R6 gathered buffer word", int'(hrd[n]), int'(wexp(r, a)));
      end
      host_idle();
      check_quiet("R1 idle between runs");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", t_checks + mon_checks, t_fails + mon_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", t_checks + mon_checks + 1, t_fails + mon_fails + 1);
    $finish;
  end

endmodule